// File: doc/BRIEF.md
# Miss-Status Entry Pool

This block holds a small pool of entries that track cache lines still missing from a data cache. Load and store requesters present a line address that missed in the tag lookup. In the same cycle the pool answers with one of three results. It can allocate a free entry. It can merge the request into a live entry for the same line. Or it can tell the requester to replay the access later. The requester is never stalled.

Each entry then runs its own sequence. First it sends an Acquire for the line to the next-level cache and waits for that cache's early hint. Next it asks the main pipeline to refill the line. When the pipeline reports the refill complete, the entry sends the line back to any load that waits on it and acknowledges any store that was merged in. If the evicted victim was dirty, the entry also posts a writeback (Release) request before it frees itself.

The Acquire, refill and writeback requests each share one outbound channel. A valid/ready handshake governs each channel. On each channel the lowest-numbered waiting entry wins, and a presented request is held unchanged until it is accepted.

Top module: `miss_entry_pool`

## Requirements
- R1: With no live entry for the address, a request takes the lowest-numbered idle entry, reports `req_replay`=0 and `req_merged`=0, and returns that entry index on `req_slot`.
- R2: A request whose address matches a live entry that is waiting on its Acquire, its hint or its refill request merges into that entry. It reports `req_merged`=1 and that entry's index, and it allocates nothing.
- R3: A request that can neither merge nor allocate asserts `req_replay`=1. This covers a full pool, and also a matching entry that has already finished its refill.
- R4: A newly allocated entry presents one Acquire carrying its address and index. When several entries wait, the lowest index is presented. A presented Acquire keeps the same index and address until `acq_ready` is high.
- R5: An entry raises a refill request only after `hint_valid` names its index while it waits for the hint. A hint that names an entry in any other state has no effect.
- R6: Refill requests are presented one at a time, lowest index first. A presented refill keeps the same index and address until `rf_ready` is high.
- R7: In the cycle after `rd_valid` names an entry whose refill was accepted, `ld_resp_valid` pulses with that entry's address and `rd_data` if any load is attached. In the same cycle `st_ack_valid` pulses with the address if any store is attached.
- R8: If the completion reports `rd_victim_dirty`=1, the entry presents `wb_valid` with `rd_victim_addr` and stays occupied until `wb_ready` accepts it. A clean completion frees the entry at once.
- R9: After reset every entry is idle, and `acq_valid`, `rf_valid`, `wb_valid`, `ld_resp_valid` and `st_ack_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_is_store | input | 1 | 1 = store miss, 0 = load miss |
| req_addr | input | ADDR_W | Missing line address |
| req_replay | output | 1 | Allocation failed; requester must replay |
| req_merged | output | 1 | Request merged into a live entry |
| req_slot | output | IDX_W | Entry index that was allocated or merged into |
| acq_valid | output | 1 | Acquire request valid |
| acq_ready | input | 1 | Acquire accepted |
| acq_addr | output | ADDR_W | Acquire line address |
| acq_slot | output | IDX_W | Entry sending the Acquire |
| hint_valid | input | 1 | Early hint from the next-level cache |
| hint_slot | input | IDX_W | Entry that the hint names |
| rf_valid | output | 1 | Refill request to the main pipeline |
| rf_ready | input | 1 | Refill request accepted |
| rf_addr | output | ADDR_W | Refill line address |
| rf_slot | output | IDX_W | Entry requesting the refill |
| rd_valid | input | 1 | Refill completed by the main pipeline |
| rd_slot | input | IDX_W | Entry whose refill completed |
| rd_victim_dirty | input | 1 | Evicted victim needs a writeback |
| rd_victim_addr | input | ADDR_W | Evicted victim line address |
| rd_data | input | LINE_W | Refilled line data |
| ld_resp_valid | output | 1 | Load response pulse |
| ld_resp_addr | output | ADDR_W | Line address of the load response |
| ld_resp_data | output | LINE_W | Forwarded line data |
| st_ack_valid | output | 1 | Store acknowledge pulse |
| st_ack_addr | output | ADDR_W | Line address of the acknowledged store |
| wb_valid | output | 1 | Writeback (Release) request |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Victim line address for the writeback |

## Verification
The bench fills the pool, then merges into two waiting entries, then overflows the pool. A design that allocated duplicate entries for one line, or that stalled instead of replaying, would show the wrong slot or flag in that same cycle.

It sends a hint to an entry whose Acquire was not yet accepted. A design that skipped the hint gating would then raise a refill early. It holds `acq_ready` and `rf_ready` low while a lower-numbered entry becomes eligible; a design without the grant lock would switch the presented index while the request is still pending.

The dirty-victim completion is checked twice. First the entry must stay occupied, so a new request replays until `wb_ready` is given. Once the writeback is accepted, the freed index must be reused.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_WAIT_HINT,
      ST_REFILL_REQ,
      ST_REFILL_DONE
   } mshr_state_e;
endpackage

// File: rtl/hold_arb.sv
module hold_arb #(
   parameter int N     = 4,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic          ready_i,
   output logic          valid_o,
   output logic [IW-1:0] idx_o
);
   logic          lock_q;
   logic [IW-1:0] lock_idx_q;
   logic [IW-1:0] pick;

   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req_i[i]) pick = IW'(i);
   end

   assign valid_o = |req_i;
   assign idx_o   = lock_q ? lock_idx_q : pick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q     <= 1'b0;
         lock_idx_q <= '0;
      end else begin
         lock_q     <= valid_o && !ready_i;
         lock_idx_q <= idx_o;
      end
   end

   // R4 R6 R8
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && idx_o == $past(idx_o)));
endmodule

// File: rtl/mshr_slot.sv
module mshr_slot
   import mshr_pkg::*;
#(
   parameter int ADDR_W = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              merge_i,
   input  logic              is_store_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              acq_acc_i,
   input  logic              hint_i,
   input  logic              rf_acc_i,
   input  logic              done_i,
   input  logic              done_dirty_i,
   input  logic [ADDR_W-1:0] done_vaddr_i,
   input  logic              wb_acc_i,
   output mshr_state_e       state_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              has_load_o,
   output logic              has_store_o,
   output logic              wb_pend_o,
   output logic [ADDR_W-1:0] vaddr_o
);
   mshr_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_o      <= '0;
         has_load_o  <= 1'b0;
         has_store_o <= 1'b0;
         wb_pend_o   <= 1'b0;
         vaddr_o     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (alloc_i) begin
               state_q     <= ST_ACQ;
               addr_o      <= req_addr_i;
               has_load_o  <= !is_store_i;
               has_store_o <= is_store_i;
            end
            ST_ACQ:        if (acq_acc_i) state_q <= ST_WAIT_HINT;
            ST_WAIT_HINT:  if (hint_i)    state_q <= ST_REFILL_REQ;
            ST_REFILL_REQ: if (rf_acc_i)  state_q <= ST_REFILL_DONE;
            ST_REFILL_DONE: begin
               if (wb_pend_o) begin
                  if (wb_acc_i) begin
                     wb_pend_o <= 1'b0;
                     state_q   <= ST_IDLE;
                  end
               end else if (done_i) begin
                  if (done_dirty_i) begin
                     wb_pend_o <= 1'b1;
                     vaddr_o   <= done_vaddr_i;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (merge_i) begin
            if (is_store_i) has_store_o <= 1'b1;
            else            has_load_o  <= 1'b1;
         end
      end
   end

   assign state_o = state_q;

   // R1
   alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> state_q == ST_IDLE);
   // R5
   hint_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_HINT && !hint_i) |=> state_q == ST_WAIT_HINT);
endmodule

// File: rtl/miss_entry_pool.sv
module miss_entry_pool
   import mshr_pkg::*;
#(
   parameter int N_ENTRY = 4,
   parameter int ADDR_W  = 34,
   parameter int LINE_W  = 512,
   localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_is_store,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_replay,
   output logic              req_merged,
   output logic [IDX_W-1:0]  req_slot,
   output logic              acq_valid,
   input  logic              acq_ready,
   output logic [ADDR_W-1:0] acq_addr,
   output logic [IDX_W-1:0]  acq_slot,
   input  logic              hint_valid,
   input  logic [IDX_W-1:0]  hint_slot,
   output logic              rf_valid,
   input  logic              rf_ready,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [IDX_W-1:0]  rf_slot,
   input  logic              rd_valid,
   input  logic [IDX_W-1:0]  rd_slot,
   input  logic              rd_victim_dirty,
   input  logic [ADDR_W-1:0] rd_victim_addr,
   input  logic [LINE_W-1:0] rd_data,
   output logic              ld_resp_valid,
   output logic [ADDR_W-1:0] ld_resp_addr,
   output logic [LINE_W-1:0] ld_resp_data,
   output logic              st_ack_valid,
   output logic [ADDR_W-1:0] st_ack_addr,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr
);
   if (N_ENTRY < 2 || N_ENTRY > 16) begin : g_bad_entries
      $error("miss_entry_pool: N_ENTRY must lie in 2..16");
   end
   if (ADDR_W < 1 || LINE_W < 8) begin : g_bad_widths
      $error("miss_entry_pool: address or line width too small");
   end

   mshr_state_e       st       [N_ENTRY];
   logic [ADDR_W-1:0] s_addr   [N_ENTRY];
   logic [ADDR_W-1:0] s_vaddr  [N_ENTRY];
   logic [N_ENTRY-1:0] s_load, s_store, s_wbp;
   logic [N_ENTRY-1:0] free_v, match_v, mhit_v, acq_req, rf_req;
   logic [N_ENTRY-1:0] alloc_v, merge_v;
   logic [IDX_W-1:0]  free_idx, mhit_idx;
   logic [IDX_W-1:0]  wb_idx;
   logic              do_merge, do_alloc;

   // lookup: which entries match, which are free
   always_comb begin
      for (int i = 0; i < N_ENTRY; i++) begin
         free_v[i]  = (st[i] == ST_IDLE);
         match_v[i] = !free_v[i] && (s_addr[i] == req_addr);
         mhit_v[i]  = match_v[i] && (st[i] != ST_REFILL_DONE);
         acq_req[i] = (st[i] == ST_ACQ);
         rf_req[i]  = (st[i] == ST_REFILL_REQ);
      end
      free_idx = '0;
      mhit_idx = '0;
      for (int i = N_ENTRY - 1; i >= 0; i--) begin
         if (free_v[i]) free_idx = IDX_W'(i);
         if (mhit_v[i]) mhit_idx = IDX_W'(i);
      end
   end

   assign do_merge   = req_valid && (|mhit_v);
   assign do_alloc   = req_valid && !(|match_v) && (|free_v);
   assign req_merged = do_merge;
   assign req_replay = req_valid && !do_merge && !do_alloc;
   assign req_slot   = do_merge ? mhit_idx : free_idx;

   always_comb begin
      for (int i = 0; i < N_ENTRY; i++) begin
         alloc_v[i] = do_alloc && (free_idx == IDX_W'(i));
         merge_v[i] = do_merge && (mhit_idx == IDX_W'(i));
      end
   end

   hold_arb #(.N(N_ENTRY)) u_acq_arb (
      .clk(clk), .rst_n(rst_n), .req_i(acq_req), .ready_i(acq_ready),
      .valid_o(acq_valid), .idx_o(acq_slot));
   hold_arb #(.N(N_ENTRY)) u_rf_arb (
      .clk(clk), .rst_n(rst_n), .req_i(rf_req), .ready_i(rf_ready),
      .valid_o(rf_valid), .idx_o(rf_slot));
   hold_arb #(.N(N_ENTRY)) u_wb_arb (
      .clk(clk), .rst_n(rst_n), .req_i(s_wbp), .ready_i(wb_ready),
      .valid_o(wb_valid), .idx_o(wb_idx));

   assign acq_addr = s_addr[acq_slot];
   assign rf_addr  = s_addr[rf_slot];
   assign wb_addr  = s_vaddr[wb_idx];

   for (genvar g = 0; g < N_ENTRY; g++) begin : g_slot
      mshr_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .alloc_i      (alloc_v[g]),
         .merge_i      (merge_v[g]),
         .is_store_i   (req_is_store),
         .req_addr_i   (req_addr),
         .acq_acc_i    (acq_valid && acq_ready && acq_slot == IDX_W'(g)),
         .hint_i       (hint_valid && hint_slot == IDX_W'(g)),
         .rf_acc_i     (rf_valid && rf_ready && rf_slot == IDX_W'(g)),
         .done_i       (rd_valid && rd_slot == IDX_W'(g)),
         .done_dirty_i (rd_victim_dirty),
         .done_vaddr_i (rd_victim_addr),
         .wb_acc_i     (wb_valid && wb_ready && wb_idx == IDX_W'(g)),
         .state_o      (st[g]),
         .addr_o       (s_addr[g]),
         .has_load_o   (s_load[g]),
         .has_store_o  (s_store[g]),
         .wb_pend_o    (s_wbp[g]),
         .vaddr_o      (s_vaddr[g])
      );
   end

   // completion responses, one cycle after rd_valid
   logic rd_live;
   assign rd_live = rd_valid && (st[rd_slot] == ST_REFILL_DONE) && !s_wbp[rd_slot];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_resp_valid <= 1'b0;
         st_ack_valid  <= 1'b0;
         ld_resp_addr  <= '0;
         ld_resp_data  <= '0;
         st_ack_addr   <= '0;
      end else begin
         ld_resp_valid <= rd_live && s_load[rd_slot];
         st_ack_valid  <= rd_live && s_store[rd_slot];
         if (rd_live) begin
            ld_resp_addr <= s_addr[rd_slot];
            ld_resp_data <= rd_data;
            st_ack_addr  <= s_addr[rd_slot];
         end
      end
   end

   // R4
   acq_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_valid && !acq_ready) |=> $stable(acq_addr));
   // R6
   rf_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !rf_ready) |=> $stable(rf_addr));
   // R7
   resp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_resp_valid || st_ack_valid) |-> $past(rd_valid));
   // R3
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({req_replay, req_merged, do_alloc}) == (req_valid ? 1 : 0));

   for (genvar a = 0; a < N_ENTRY; a++) begin : g_uniq_a
      for (genvar b = a + 1; b < N_ENTRY; b++) begin : g_uniq_b
         // R2
         uniq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(st[a] != ST_IDLE && st[b] != ST_IDLE && s_addr[a] == s_addr[b]));
      end
   end
endmodule

// File: tb/test_miss_entry_pool.sv
`timescale 1ns/1ps
module test_miss_entry_pool;
   localparam int AW = 34;
   localparam int LW = 512;
   localparam int IW = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, req_valid, req_is_store, req_replay, req_merged;
   logic [AW-1:0] req_addr, acq_addr, rf_addr, rd_victim_addr, ld_resp_addr, st_ack_addr, wb_addr;
   logic [IW-1:0] req_slot, acq_slot, hint_slot, rf_slot, rd_slot;
   logic acq_valid, acq_ready, hint_valid, rf_valid, rf_ready, rd_valid, rd_victim_dirty;
   logic ld_resp_valid, st_ack_valid, wb_valid, wb_ready;
   logic [LW-1:0] rd_data, ld_resp_data;

   miss_entry_pool i_miss_entry_pool (.*);

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic req(input logic [AW-1:0] a, input logic st);
      req_valid = 1'b1; req_addr = a; req_is_store = st;
   endtask

   localparam logic [AW-1:0] A = 34'h1000, B = 34'h2000, C = 34'h3000, D = 34'h4000;
   localparam logic [AW-1:0] E = 34'h5000, F = 34'h6000, G = 34'h7000, V = 34'h0ABC;

   // vector: addr, store, kind (0 alloc, 1 merge, 2 replay), slot
   localparam int NV = 8;
   localparam logic [AW+4:0] VEC [NV] = '{
      {A, 1'b0, 2'd0, 2'd0},   // R1
      {B, 1'b0, 2'd0, 2'd1},   // R1
      {A, 1'b1, 2'd1, 2'd0},   // R2
      {C, 1'b1, 2'd0, 2'd2},   // R1
      {D, 1'b0, 2'd0, 2'd3},   // R1
      {E, 1'b0, 2'd2, 2'd0},   // R3 pool full
      {B, 1'b1, 2'd1, 2'd1},   // R2
      {D, 1'b1, 2'd1, 2'd3}    // R2
   };

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b0; req_addr = '0;
      acq_ready = 1'b0; hint_valid = 1'b0; hint_slot = '0; rf_ready = 1'b0;
      rd_valid = 1'b0; rd_slot = '0; rd_victim_dirty = 1'b0; rd_victim_addr = '0;
      rd_data = '0; wb_ready = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk(!acq_valid && !rf_valid && !wb_valid && !ld_resp_valid && !st_ack_valid,
          "R9 reset valids", {acq_valid, rf_valid, wb_valid, ld_resp_valid, st_ack_valid}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [AW+4:0] v;
         v = VEC[i];
         req(v[AW+4:5], v[4]);
         #1;
         case (v[3:2])
            2'd0: chk(!req_replay && !req_merged && req_slot == v[1:0], "R1 alloc slot",
                      {req_replay, req_merged, req_slot}, {2'b00, v[1:0]});
            2'd1: chk(req_merged && !req_replay && req_slot == v[1:0], "R2 merge slot",
                      {req_replay, req_merged, req_slot}, {2'b01, v[1:0]});
            default: chk(req_replay && !req_merged, "R3 replay",
                      {req_replay, req_merged}, 2'b10);
         endcase
         step();
         req_valid = 1'b0;
      end

      // hint to an entry still presenting its Acquire
      hint_valid = 1'b1; hint_slot = 2'd1;
      #1;
      chk(acq_valid && acq_slot == 0 && acq_addr == A, "R4 acquire lowest held", acq_slot, 0);
      step();
      hint_valid = 1'b0;
      chk(acq_valid && acq_slot == 0, "R4 acquire held while not ready", acq_slot, 0);

      acq_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk(acq_valid && acq_slot == IW'(k), "R4 acquire order", acq_slot, k);
         step();
      end
      acq_ready = 1'b0;
      chk(!acq_valid, "R4 acquires drained", acq_valid, 0);
      chk(!rf_valid, "R5 early hint ignored", rf_valid, 0);

      hint_valid = 1'b1; hint_slot = 2'd2;
      step();
      hint_slot = 2'd1;
      #1;
      chk(rf_valid && rf_slot == 2 && rf_addr == C, "R5 refill after hint", rf_slot, 2);
      step();
      hint_valid = 1'b0;
      chk(rf_valid && rf_slot == 2, "R6 refill grant held", rf_slot, 2);
      rf_ready = 1'b1;
      step();
      chk(rf_valid && rf_slot == 1 && rf_addr == B, "R6 next refill", rf_slot, 1);
      step();
      rf_ready = 1'b0;
      chk(!rf_valid, "R6 refills drained", rf_valid, 0);

      // clean completion for entry 1 (load + store attached)
      rd_valid = 1'b1; rd_slot = 2'd1; rd_victim_dirty = 1'b0;
      rd_data = {16{32'hCAFE_0123}};
      chk(!ld_resp_valid, "R7 no response before edge", ld_resp_valid, 0);
      step();
      rd_valid = 1'b0;
      chk(ld_resp_valid && ld_resp_addr == B, "R7 load response", ld_resp_addr, B);
      chk(ld_resp_data == {16{32'hCAFE_0123}}, "R7 load data", ld_resp_data[63:0], 64'hCAFE_0123_CAFE_0123);
      chk(st_ack_valid && st_ack_addr == B, "R7 store ack", st_ack_addr, B);
      chk(!wb_valid, "R8 clean victim no writeback", wb_valid, 0);
      req(F, 1'b0);
      #1;
      chk(!req_replay && req_slot == 1, "R8 clean entry freed", req_slot, 1);
      step();
      req_valid = 1'b0;
      chk(!ld_resp_valid && !st_ack_valid, "R7 response is a pulse", {ld_resp_valid, st_ack_valid}, 0);

      // dirty completion for entry 2 (store only)
      rd_valid = 1'b1; rd_slot = 2'd2; rd_victim_dirty = 1'b1; rd_victim_addr = V;
      step();
      rd_valid = 1'b0; rd_victim_dirty = 1'b0;
      chk(st_ack_valid && st_ack_addr == C, "R7 store-only ack", st_ack_addr, C);
      chk(!ld_resp_valid, "R7 no load response for store-only", ld_resp_valid, 0);
      chk(wb_valid && wb_addr == V, "R8 writeback posted", wb_addr, V);
      step();
      chk(wb_valid && wb_addr == V, "R8 writeback held", wb_addr, V);
      req(G, 1'b0);
      #1;
      chk(req_replay, "R8 entry occupied until writeback", req_replay, 1);
      req_valid = 1'b0;
      wb_ready = 1'b1;
      step();
      wb_ready = 1'b0;
      chk(!wb_valid, "R8 writeback accepted", wb_valid, 0);
      req(G, 1'b0);
      #1;
      chk(!req_replay && req_slot == 2, "R8 entry reused after writeback", req_slot, 2);
      step();
      req_valid = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule